// File: doc/BRIEF.md
# Transfer Status and Interrupt Logger

This block sits beside the two sequencers of a host-to-wide-bus bridge and records how each bridged transfer ended. It keeps a 16-bit event register and a 16-bit control/status register that the host reads through a small register port. When a transfer ends abnormally, the block records what went wrong and the window offset of the transfer involved. It can also carry a short message from a wide-bus master to the host. An interrupt request is raised when an enabled event class occurs.

The block owns three watchdogs. Two count clock cycles while the bridge waits for the remote slave's address handshake and data handshake. The third is a prescaled counter that times a whole word transfer, arbitration included, against a long limit. The remaining events come in as one-cycle strobes from the sequencers.

Once an interrupt is raised, the event register is frozen so that software reads the first event intact. Any event that cannot be recorded is lost, but it sets an overflow flag. Software releases the lock by writing 1 to the interrupt flag.

Top module: `xfer_status_logger`

## Requirements
- R1: Reset (synchronous, active high) clears the event register and the control/status register to 0 and drops irq.
- R2: A txn_start strobe loads the status bits: bit 0 is set when the wide bus started the transfer, bit 1 marks a block transfer, bit 2 a write, and bit 3 a pending second host word. These bits ignore host writes.
- R3: When addr_wait stays high for ADDR_TMO_CYC consecutive clock edges, event code 1 is recorded on that edge and not before. A low addr_wait restarts the count.
- R4: When data_wait stays high for DATA_TMO_CYC consecutive edges, event code 2 is recorded. The same rule applies.
- R5: An ack_evt strobe records code 3 when only busy is flagged, code 4 when only empty is flagged, and code 5 when both are flagged. An ack with neither flag records nothing.
- R6: align_evt records code 6. dma_last_evt records code 8. When xfer_busy stays high for LONG_PRESCALE*LONG_TICKS edges, code 7 is recorded.
- R7: For codes 1 to 8, the event register holds the code in bits [15:12] and the offset latched at the last txn_start in bits [11:0]. A msg_we strobe (code 9) stores {1, msg_data[14:0]}.
- R8: Every recorded event sets the ERROR bit (status bit 4) and the class field (bits [6:5]). The class is 01 for codes 1–7, 10 for code 8 and 11 for code 9. Writing 1 to bit 4 clears ERROR.
- R9: Enable bits [14:9] gate the interrupt for codes 1, 2, 6, 7, 8 and 9, in that bit order. Codes 3–5 are gated by be_irq_en instead. A recorded event that is enabled sets INTERRUPT (bit 7), and irq follows that bit. A recorded event that is disabled updates the registers but raises nothing.
- R10: While INTERRUPT is set, events leave the event register and the class field unchanged and set OVERFLOW (bit 8).
- R11: Writing 1 to bit 7 clears INTERRUPT and OVERFLOW. An event in the same cycle is recorded as though it came after the clear.
- R12: When several events arrive in one cycle, the lowest code is recorded and OVERFLOW is set.
- R13: A host write to the status register (host_sel=1) loads the enable bits [14:9], and they read back unchanged. host_sel=0 reads the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Strobe: new transfer begins, latch attributes and offset |
| txn_remote | input | 1 | Transfer started by the wide bus |
| txn_block | input | 1 | Transfer is part of a block |
| txn_write | input | 1 | Transfer is a write |
| txn_second | input | 1 | Second host word pending |
| txn_off | input | 12 | Host window offset of the transfer |
| addr_wait | input | 1 | Waiting for the remote address handshake |
| data_wait | input | 1 | Waiting for the remote data handshake |
| xfer_busy | input | 1 | Word transfer in progress, arbitration included |
| ack_evt | input | 1 | Strobe: data handshake returned |
| ack_busy | input | 1 | Busy flag returned with the handshake |
| ack_empty | input | 1 | Empty flag returned with the handshake |
| be_irq_en | input | 1 | Interrupt enable for busy/empty events of this window |
| align_evt | input | 1 | Strobe: the two host words disagree on direction |
| dma_last_evt | input | 1 | Strobe: last word of a DMA block |
| msg_we | input | 1 | Strobe: remote master writes a message |
| msg_data | input | 15 | Message payload |
| host_we | input | 1 | Host register write |
| host_sel | input | 1 | 1 = status register, 0 = event register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_sel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, the properties that hold at any moment. A locked event register never changes unless software clears it. Raising the interrupt always comes with ERROR set. A clear with no coincident event leaves both flags low. An unlocked message lands whole with class 11. The enable bits follow host writes.

The bench shows what only a planned sequence can reveal. It sweeps every event code with enables on and off, followed by a second event. It checks the exact edge on which each watchdog fires. It also checks that the priority is right when events coincide, and that a clear coinciding with an event behaves correctly.

// File: rtl/xsl_pkg.sv
package xsl_pkg;

    localparam int OFF_W  = 12;
    localparam int REG_W  = 16;
    localparam int NUM_EV = 9;
    localparam int EN_W   = 6;

    typedef enum logic [3:0] {
        EV_NONE     = 4'd0,
        EV_ADDR_TMO = 4'd1,
        EV_DATA_TMO = 4'd2,
        EV_BUSY     = 4'd3,
        EV_EMPTY    = 4'd4,
        EV_BOTH     = 4'd5,
        EV_ALIGN    = 4'd6,
        EV_LONG_TMO = 4'd7,
        EV_DMA_LAST = 4'd8,
        EV_MESSAGE  = 4'd9
    } evt_code_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'b00,
        CLS_FAULT = 2'b01,
        CLS_LAST  = 2'b10,
        CLS_MSG   = 2'b11
    } evt_cls_e;

    typedef struct packed {
        logic second;
        logic wr;
        logic blk;
        logic remote;
    } attr_t;

    typedef struct packed {
        logic            rsvd;
        logic [EN_W-1:0] en;
        logic            ovf;
        logic            intr;
        evt_cls_e        cls;
        logic            err;
        attr_t           attr;
    } csr_t;

    function automatic evt_cls_e cls_of(evt_code_e c);
        case (c)
            EV_NONE:     return CLS_NONE;
            EV_DMA_LAST: return CLS_LAST;
            EV_MESSAGE:  return CLS_MSG;
            default:     return CLS_FAULT;
        endcase
    endfunction

    function automatic logic irq_allowed(evt_code_e c, logic [EN_W-1:0] en, logic be_en);
        case (c)
            EV_ADDR_TMO:               return en[0];
            EV_DATA_TMO:               return en[1];
            EV_BUSY, EV_EMPTY, EV_BOTH: return be_en;
            EV_ALIGN:                  return en[2];
            EV_LONG_TMO:               return en[3];
            EV_DMA_LAST:               return en[4];
            EV_MESSAGE:                return en[5];
            default:                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xsl_wait_timer.sv
module xsl_wait_timer #(
    parameter int LIMIT = 8,
    parameter bit WRAP  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic adv,
    output logic fire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == W'(LIMIT - 1));
    assign fire   = run && adv && at_end;

    generate
        if (WRAP) begin : g_wrap
            always_ff @(posedge clk) begin
                if (rst || !run)
                    cnt_q <= '0;
                else if (adv)
                    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
            end
        end else begin : g_sat
            always_ff @(posedge clk) begin
                if (rst || !run)
                    cnt_q <= '0;
                else if (adv && cnt_q != W'(LIMIT))
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/xsl_event_encode.sv
module xsl_event_encode
    import xsl_pkg::*;
(
    input  logic      fire_addr,
    input  logic      fire_data,
    input  logic      ack_evt,
    input  logic      ack_busy,
    input  logic      ack_empty,
    input  logic      align_evt,
    input  logic      fire_long,
    input  logic      dma_last_evt,
    input  logic      msg_we,
    output logic      evt_valid,
    output logic      evt_multi,
    output evt_code_e evt_code
);
    logic [NUM_EV:1] req;
    int              n_req;

    always_comb begin
        req[1] = fire_addr;
        req[2] = fire_data;
        req[3] = ack_evt && ack_busy && !ack_empty;
        req[4] = ack_evt && ack_empty && !ack_busy;
        req[5] = ack_evt && ack_busy && ack_empty;
        req[6] = align_evt;
        req[7] = fire_long;
        req[8] = dma_last_evt;
        req[9] = msg_we;
    end

    always_comb begin
        evt_code = EV_NONE;
        n_req    = 0;
        for (int i = NUM_EV; i >= 1; i--) begin
            if (req[i]) begin
                evt_code = evt_code_e'(i[3:0]);
                n_req    = n_req + 1;
            end
        end
        evt_valid = (n_req != 0);
        evt_multi = (n_req > 1);
    end
endmodule

// File: rtl/xsl_regs.sv
module xsl_regs
    import xsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_start,
    input  attr_t            txn_attr,
    input  logic [OFF_W-1:0] txn_off,
    input  logic             evt_valid,
    input  logic             evt_multi,
    input  evt_code_e        evt_code,
    input  logic             be_irq_en,
    input  logic [14:0]      msg_data,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] ir_val,
    output csr_t             csr_val
);
    logic [REG_W-1:0] ir_q;
    logic [OFF_W-1:0] off_q;
    attr_t            attr_q;
    logic             err_q, int_q, ovf_q;
    evt_cls_e         cls_q;
    logic [EN_W-1:0]  en_q;

    logic csr_wr, clr_int, clr_err, locked, record, lost, raise;

    always_comb begin
        csr_wr  = host_we && host_sel;
        clr_int = csr_wr && host_wdata[7];
        clr_err = csr_wr && host_wdata[4];
        locked  = int_q && !clr_int;
        record  = evt_valid && !locked;
        lost    = (evt_valid && locked) || evt_multi;
        raise   = record && irq_allowed(evt_code, en_q, be_irq_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q   <= '0;
            off_q  <= '0;
            attr_q <= '0;
            err_q  <= 1'b0;
            int_q  <= 1'b0;
            ovf_q  <= 1'b0;
            cls_q  <= CLS_NONE;
            en_q   <= '0;
        end else begin
            if (txn_start) begin
                attr_q <= txn_attr;
                off_q  <= txn_off;
            end
            if (csr_wr)
                en_q <= host_wdata[14:9];
            if (record) begin
                ir_q  <= (evt_code == EV_MESSAGE) ? {1'b1, msg_data}
                                                  : {evt_code, off_q};
                cls_q <= cls_of(evt_code);
                err_q <= 1'b1;
            end else if (clr_err) begin
                err_q <= 1'b0;
            end
            if (raise)
                int_q <= 1'b1;
            else if (clr_int)
                int_q <= 1'b0;
            if (lost)
                ovf_q <= 1'b1;
            else if (clr_int)
                ovf_q <= 1'b0;
        end
    end

    always_comb begin
        ir_val       = ir_q;
        csr_val      = '0;
        csr_val.attr = attr_q;
        csr_val.err  = err_q;
        csr_val.cls  = cls_q;
        csr_val.intr = int_q;
        csr_val.ovf  = ovf_q;
        csr_val.en   = en_q;
    end
endmodule

// File: rtl/xfer_status_logger.sv
module xfer_status_logger
    import xsl_pkg::*;
#(
    parameter int ADDR_TMO_CYC  = 200,
    parameter int DATA_TMO_CYC  = 150,
    parameter int LONG_PRESCALE = 500,
    parameter int LONG_TICKS    = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        txn_start,
    input  logic        txn_remote,
    input  logic        txn_block,
    input  logic        txn_write,
    input  logic        txn_second,
    input  logic [11:0] txn_off,
    input  logic        addr_wait,
    input  logic        data_wait,
    input  logic        xfer_busy,
    input  logic        ack_evt,
    input  logic        ack_busy,
    input  logic        ack_empty,
    input  logic        be_irq_en,
    input  logic        align_evt,
    input  logic        dma_last_evt,
    input  logic        msg_we,
    input  logic [14:0] msg_data,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq
);
    logic      fire_addr, fire_data, pre_tick, fire_long;
    logic      evt_valid, evt_multi;
    evt_code_e evt_code;
    logic [REG_W-1:0] ir_val;
    csr_t      csr_val;
    attr_t     txn_attr;

    assign txn_attr = '{second: txn_second, wr: txn_write,
                        blk: txn_block, remote: txn_remote};

    xsl_wait_timer #(.LIMIT(ADDR_TMO_CYC), .WRAP(1'b0)) i_addr_tmr (
        .clk(clk), .rst(rst), .run(addr_wait), .adv(1'b1), .fire(fire_addr));

    xsl_wait_timer #(.LIMIT(DATA_TMO_CYC), .WRAP(1'b0)) i_data_tmr (
        .clk(clk), .rst(rst), .run(data_wait), .adv(1'b1), .fire(fire_data));

    xsl_wait_timer #(.LIMIT(LONG_PRESCALE), .WRAP(1'b1)) i_pre_tmr (
        .clk(clk), .rst(rst), .run(xfer_busy), .adv(1'b1), .fire(pre_tick));

    xsl_wait_timer #(.LIMIT(LONG_TICKS), .WRAP(1'b0)) i_long_tmr (
        .clk(clk), .rst(rst), .run(xfer_busy), .adv(pre_tick), .fire(fire_long));

    xsl_event_encode i_enc (
        .fire_addr(fire_addr), .fire_data(fire_data),
        .ack_evt(ack_evt), .ack_busy(ack_busy), .ack_empty(ack_empty),
        .align_evt(align_evt), .fire_long(fire_long),
        .dma_last_evt(dma_last_evt), .msg_we(msg_we),
        .evt_valid(evt_valid), .evt_multi(evt_multi), .evt_code(evt_code));

    xsl_regs i_regs (
        .clk(clk), .rst(rst),
        .txn_start(txn_start), .txn_attr(txn_attr), .txn_off(txn_off),
        .evt_valid(evt_valid), .evt_multi(evt_multi), .evt_code(evt_code),
        .be_irq_en(be_irq_en), .msg_data(msg_data),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .ir_val(ir_val), .csr_val(csr_val));

    assign host_rdata = host_sel ? 16'(csr_val) : ir_val;
    assign irq        = csr_val.intr;
endmodule

// File: rtl/xsl_logger_chk.sv
module xsl_logger_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_we,
    input logic        host_sel,
    input logic [15:0] host_wdata,
    input logic        msg_we,
    input logic [14:0] msg_data,
    input logic [15:0] ir,
    input logic [15:0] csr,
    input logic        evt_valid,
    input logic [3:0]  evt_code
);
    logic clr_wr;
    assign clr_wr = host_we && host_sel && host_wdata[7];

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (ir == 16'h0 && csr == 16'h0));

    // R10
    locked_ir_chk: assert property (@(posedge clk) disable iff (rst)
        (csr[7] && !clr_wr) |=> $stable(ir));

    // R8
    err_with_int_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(csr[7]) |-> csr[4]);

    // R11
    clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !evt_valid) |=> (!csr[7] && !csr[8]));

    // R7
    msg_store_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_we && !csr[7] && evt_code == 4'd9)
            |=> (ir == {1'b1, $past(msg_data)} && csr[6:5] == 2'b11));

    // R13
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel) |=> (csr[14:9] == $past(host_wdata[14:9])));
endmodule

bind xfer_status_logger xsl_logger_chk i_chk (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .msg_we(msg_we), .msg_data(msg_data),
    .ir(ir_val), .csr(16'(csr_val)),
    .evt_valid(evt_valid), .evt_code(evt_code));

// File: tb/test_xfer_status_logger.sv
`timescale 1ns/1ps
module test_xfer_status_logger;
    localparam int A_LIM = 5;
    localparam int D_LIM = 4;
    localparam int PRE   = 3;
    localparam int TICKS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 0, txn_remote = 0, txn_block = 0, txn_write = 0, txn_second = 0;
    logic [11:0] txn_off = '0;
    logic addr_wait = 0, data_wait = 0, xfer_busy = 0;
    logic ack_evt = 0, ack_busy = 0, ack_empty = 0, be_irq_en = 0;
    logic align_evt = 0, dma_last_evt = 0, msg_we = 0;
    logic [14:0] msg_data = '0;
    logic host_we = 0, host_sel = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model, from the requirements
    logic [15:0] m_ir = '0;
    logic [11:0] m_off = '0;
    logic [3:0]  m_attr = '0;
    logic        m_err = 0, m_int = 0, m_ovf = 0;
    logic [1:0]  m_cls = '0;
    logic [5:0]  m_en = '0;

    always #10 clk = ~clk;

    xfer_status_logger #(.ADDR_TMO_CYC(A_LIM), .DATA_TMO_CYC(D_LIM),
                         .LONG_PRESCALE(PRE), .LONG_TICKS(TICKS)) i_xfer_status_logger (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_remote(txn_remote),
        .txn_block(txn_block), .txn_write(txn_write), .txn_second(txn_second),
        .txn_off(txn_off), .addr_wait(addr_wait), .data_wait(data_wait),
        .xfer_busy(xfer_busy), .ack_evt(ack_evt), .ack_busy(ack_busy),
        .ack_empty(ack_empty), .be_irq_en(be_irq_en), .align_evt(align_evt),
        .dma_last_evt(dma_last_evt), .msg_we(msg_we), .msg_data(msg_data),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_csr();
        return {1'b0, m_en, m_ovf, m_int, m_cls, m_err, m_attr};
    endfunction

    task automatic check_all(input string req);
        host_sel = 1'b0; #1;
        chk(req, host_rdata, m_ir);
        host_sel = 1'b1; #1;
        chk(req, host_rdata, m_csr());
        chk(req, {15'd0, irq}, {15'd0, m_int});
    endtask

    function automatic logic m_allowed(input int code);
        case (code)
            1: return m_en[0];
            2: return m_en[1];
            3, 4, 5: return be_irq_en;
            6: return m_en[2];
            7: return m_en[3];
            8: return m_en[4];
            9: return m_en[5];
            default: return 1'b0;
        endcase
    endfunction

    task automatic m_event(input int code, input logic [14:0] msg);
        if (m_int) m_ovf = 1'b1;
        else begin
            m_ir  = (code == 9) ? {1'b1, msg} : {4'(code), m_off};
            m_err = 1'b1;
            m_cls = (code == 9) ? 2'b11 : (code == 8) ? 2'b10 : 2'b01;
            if (m_allowed(code)) m_int = 1'b1;
        end
    endtask

    task automatic wr_csr(input logic [15:0] v);
        host_we = 1'b1; host_sel = 1'b1; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        m_en = v[14:9];
        if (v[7]) begin m_int = 0; m_ovf = 0; end
        if (v[4]) m_err = 0;
    endtask

    task automatic start_txn(input logic [3:0] a, input logic [11:0] off);
        txn_start = 1; {txn_second, txn_write, txn_block, txn_remote} = a; txn_off = off;
        @(negedge clk);
        txn_start = 0;
        m_attr = a; m_off = off;
    endtask

    // R3 R4 R6: hold a wait input, check the edge before the limit, then the limit edge
    task automatic run_wait(input int code, input int lim);
        case (code)
            1: addr_wait = 1;
            2: data_wait = 1;
            default: xfer_busy = 1;
        endcase
        repeat (lim - 1) @(negedge clk);
        check_all(code == 1 ? "R3 early" : code == 2 ? "R4 early" : "R6 early");
        @(negedge clk);
        addr_wait = 0; data_wait = 0; xfer_busy = 0;
    endtask

    task automatic fire(input int code, input logic [14:0] msg);
        case (code)
            1: run_wait(1, A_LIM);
            2: run_wait(2, D_LIM);
            7: run_wait(7, PRE * TICKS);
            default: begin
                case (code)
                    3: begin ack_evt = 1; ack_busy = 1; end
                    4: begin ack_evt = 1; ack_empty = 1; end
                    5: begin ack_evt = 1; ack_busy = 1; ack_empty = 1; end
                    6: align_evt = 1;
                    8: dma_last_evt = 1;
                    default: begin msg_we = 1; msg_data = msg; end
                endcase
                @(negedge clk);
                ack_evt = 0; ack_busy = 0; ack_empty = 0;
                align_evt = 0; dma_last_evt = 0; msg_we = 0;
            end
        endcase
        m_event(code, msg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1 reset");

        // R13: enables load, attribute bits ignore the write
        wr_csr(16'h540F);
        check_all("R13 enable readback");

        // R2: all attribute combinations
        for (int a = 0; a < 16; a++) begin
            start_txn(4'(a), 12'h300 + 12'(a));
            check_all("R2 attributes");
        end

        // R5 R7 R8 R9 R10: every code, interrupts off then on, with a follow-up event
        for (int pass = 0; pass < 2; pass++) begin
            be_irq_en = pass[0];
            for (int code = 1; code <= 9; code++) begin
                wr_csr({1'b0, pass[0] ? 6'h3F : 6'h00, 9'h090});
                start_txn(4'(code), 12'h100 + 12'(code * 17));
                fire(code, 15'h1234 + 15'(code));
                check_all(code == 9 ? "R7 message" : "R8 R9 record");
                fire((code % 9) + 1, 15'h0555);
                check_all(pass ? "R10 lock" : "R9 disabled overwrite");
            end
        end

        // R5: ack with no flag records nothing
        wr_csr(16'h7E90);
        ack_evt = 1; @(negedge clk); ack_evt = 0;
        check_all("R5 plain ack");

        // R11: clear coincident with an event records the event
        fire(6, '0);
        check_all("R11 locked");
        host_we = 1; host_sel = 1; host_wdata = 16'h7E80; dma_last_evt = 1;
        @(negedge clk);
        host_we = 0; dma_last_evt = 0;
        m_int = 0; m_ovf = 0; m_event(8, '0);
        check_all("R11 clear with event");

        // R8: W1C of ERROR
        wr_csr(16'h7E90);
        check_all("R8 error clear");

        // R12: simultaneous align and dma-last
        align_evt = 1; dma_last_evt = 1;
        @(negedge clk);
        align_evt = 0; dma_last_evt = 0;
        m_event(6, '0); m_ovf = 1;
        check_all("R12 simultaneous");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule